// File: doc/BRIEF.md
# Multi-Mode Prescaled Up-Counter Timer

This block is a general-purpose timer. A prescaler divides the clock and paces an up counter. The counter value is compared with a programmable compare value, and a match raises a flag. What happens on a match depends on the counting mode:

- **One-shot** stops the timer.
- **Periodic** restarts from zero.
- **Toggle** restarts from zero and inverts an output pin.
- **Continuous** lets the counter run on and wrap.

An event option counts synchronised edges of an external pin instead of prescaled clocks. Software programs the timer through a plain single-cycle register-write port. The block has no data stream, so there is no valid/ready handshake: a write is taken on every clock edge where `wr_en` is high. All status comes out on plain pins.

The `wr_sel` input picks the target of a write:

| `wr_sel` | Target | Fields and effect |
|---|---|---|
| 0 | Control | `[PSC_W-1:0]` prescale, `[9:8]` mode, `[10]` count enable, `[11]` interrupt enable, `[12]` wake enable, `[13]` event mode, `[14]` edge phase |
| 1 | Compare | `[CNT_W-1:0]` compare value |
| 2 | Flag clear | Write-one-to-clear: bit 0 is the match flag, bit 1 is the wake flag |
| 3 | Count reset | Any data |

Mode codes are 0 one-shot, 1 periodic, 2 toggle and 3 continuous. The edge phase bit selects the falling edge when 0 and the rising edge when 1. `PSC_W` may not exceed 8. Compare values 0 and 1 are not to be used.

Top module: `gp_timer`

## Requirements
- R1: After reset, `count`, `match_flag`, `wake_flag`, `irq`, `active`, `rst_busy` and `toggle_out` are all 0.
- R2: While `active` is 1 and event mode is off, the counter advances by one every (prescale+1) clock cycles.
- R3: A write of count enable (control bit 10) shows on `active` two clocks after the write edge. While `active` is 0 and no write occurs, `count` holds.
- R4: The match flag is set on the clock edge at which the counter would reach the compare value. Writing 1 to flag-clear bit 0 clears it. A set in the same cycle as a clear wins over the clear.
- R5: In one-shot mode (code 0), a match returns the counter to 0 and drops the enable and `active` at once.
- R6: In periodic mode (code 1), a match returns the counter to 0 and counting continues, so one period is the compare value times (prescale+1) cycles.
- R7: In toggle mode (code 2), a match returns the counter to 0 and inverts `toggle_out`. `toggle_out` changes in no other case.
- R8: In continuous mode (code 3), the counter passes the compare value and wraps modulo 2^CNT_W. A compare write does not disturb the counter.
- R9: In modes 0 to 2, a compare write restarts the counter and the prescaler from 0.
- R10: A control write whose prescale field differs from the current prescale restarts the counter and the prescaler from 0.
- R11: A count-reset write clears the counter and the prescaler. `rst_busy` is then 1 for RST_HOLD cycles, during which the counter stays at 0.
- R12: `irq` is the match flag ANDed with interrupt enable. The wake flag is set one cycle after `irq` is 1 while wake enable is 1. Writing 1 to flag-clear bit 1 clears the wake flag.
- R13: In event mode (control bit 13), the counter advances once per selected edge of `evt_in`, taken after a two-stage synchroniser. The prescaler is not used in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 compare, 2 flag clear, 3 count reset |
| wr_data | input | DATA_W | Write data |
| evt_in | input | 1 | External event input, asynchronous |
| count | output | CNT_W | Current counter value |
| match_flag | output | 1 | Sticky compare-match flag |
| wake_flag | output | 1 | Sticky wake flag |
| irq | output | 1 | Interrupt request |
| active | output | 1 | Counter running state |
| rst_busy | output | 1 | Count reset in progress |
| toggle_out | output | 1 | Toggle-mode output |

## Verification
The bench builds the timer with `CNT_W` of 10 and keeps the defaults for the other parameters: `PSC_W` 8, `RST_HOLD` 2 and two synchroniser stages. The narrow counter makes the continuous-mode wrap reachable in about a thousand cycles. The 8-bit prescale field is unchanged, so prescaled periods and restarts on a prescale change are exercised as they are built. A two-cycle reset hold makes the busy window longer than one edge, so holding the counter during that window is observable.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam int DATA_W     = 32;
  localparam int F_MODE_LO  = 8;
  localparam int F_EN       = 10;
  localparam int F_IEN      = 11;
  localparam int F_WEN      = 12;
  localparam int F_EVT      = 13;
  localparam int F_PHASE    = 14;
  localparam int F_CLR_MATCH = 0;
  localparam int F_CLR_WAKE  = 1;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_TOGGLE   = 2'd2,
    MODE_FREE     = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CNT  = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    tmr_mode_e mode;
    logic      ien;
    logic      wen;
    logic      evt;
    logic      phase;
  } tmr_ctrl_t;
endpackage

// File: rtl/gp_timer_regs.sv
module gp_timer_regs
  import gp_timer_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop,
  output logic [PSC_W-1:0]  psc,
  output logic [CNT_W-1:0]  cmp,
  output tmr_ctrl_t         ctrl,
  output logic              active,
  output logic              restart,
  output logic              cnt_wr,
  output logic              clr_match,
  output logic              clr_wake
);
  logic en_req, en_mid;
  logic wr_ctrl, wr_cmp, wr_stat;

  always_comb begin
    wr_ctrl   = wr_en && (tmr_sel_e'(wr_sel) == SEL_CTRL);
    wr_cmp    = wr_en && (tmr_sel_e'(wr_sel) == SEL_CMP);
    wr_stat   = wr_en && (tmr_sel_e'(wr_sel) == SEL_STAT);
    cnt_wr    = wr_en && (tmr_sel_e'(wr_sel) == SEL_CNT);
    clr_match = wr_stat && wr_data[F_CLR_MATCH];
    clr_wake  = wr_stat && wr_data[F_CLR_WAKE];
    restart   = cnt_wr
             || (wr_cmp && (ctrl.mode != MODE_FREE))
             || (wr_ctrl && (wr_data[PSC_W-1:0] != psc));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc    <= '0;
      cmp    <= '0;
      ctrl   <= '0;
      en_req <= 1'b0;
      en_mid <= 1'b0;
      active <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        psc        <= wr_data[PSC_W-1:0];
        ctrl.mode  <= tmr_mode_e'(wr_data[F_MODE_LO+1:F_MODE_LO]);
        ctrl.ien   <= wr_data[F_IEN];
        ctrl.wen   <= wr_data[F_WEN];
        ctrl.evt   <= wr_data[F_EVT];
        ctrl.phase <= wr_data[F_PHASE];
        en_req     <= wr_data[F_EN];
      end
      if (wr_cmp) cmp <= wr_data[CNT_W-1:0];
      en_mid <= en_req;
      active <= en_mid;
      if (stop) begin
        en_req <= 1'b0;
        en_mid <= 1'b0;
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gp_timer_edge.sv
module gp_timer_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  input  logic phase,
  output logic pulse
);
  localparam int LAST = SYNC_STAGES;
  logic [LAST:0] sh;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= evt_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[g] <= 1'b0;
          else     sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    if (phase) pulse = sh[LAST-1] && !sh[LAST];
    else       pulse = !sh[LAST-1] && sh[LAST];
  end
endmodule

// File: rtl/gp_timer_prescale.sv
module gp_timer_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc,
  input  logic             active,
  input  logic             busy,
  input  logic             evt_mode,
  input  logic             evt_pulse,
  input  logic             restart,
  output logic             tick
);
  logic [PSC_W-1:0] pc;
  logic             run, wrap;

  always_comb begin
    run  = active && !busy;
    wrap = (pc == psc);
    tick = run && (evt_mode ? evt_pulse : wrap);
  end

  always_ff @(posedge clk) begin
    if (rst || restart)           pc <= '0;
    else if (run && !evt_mode)    pc <= wrap ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/gp_timer_count.sv
module gp_timer_count
  import gp_timer_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int RST_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cmp,
  input  tmr_mode_e        mode,
  input  logic             ien,
  input  logic             wen,
  input  logic             clr_match,
  input  logic             clr_wake,
  output logic [CNT_W-1:0] count,
  output logic             match_flag,
  output logic             wake_flag,
  output logic             toggle_out,
  output logic             busy,
  output logic             stop
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(RST_HOLD);

  logic [CNT_W-1:0]  cnt_inc;
  logic [HOLD_W-1:0] hold;
  logic              hit;

  always_comb begin
    cnt_inc = count + 1'b1;
    hit     = tick && (cnt_inc == cmp);
    stop    = hit && (mode == MODE_ONESHOT);
    busy    = (hold != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      match_flag <= 1'b0;
      wake_flag  <= 1'b0;
      toggle_out <= 1'b0;
      hold       <= '0;
    end else begin
      if (restart)                          count <= '0;
      else if (hit && mode != MODE_FREE)    count <= '0;
      else if (tick)                        count <= cnt_inc;

      match_flag <= hit || (match_flag && !clr_match);
      wake_flag  <= (match_flag && ien && wen) || (wake_flag && !clr_wake);
      if (hit && mode == MODE_TOGGLE) toggle_out <= !toggle_out;

      if (cnt_wr)       hold <= HOLD_INIT;
      else if (busy)    hold <= hold - 1'b1;
    end
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int CNT_W       = 24,
  parameter int RST_HOLD    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt_in,
  output logic [CNT_W-1:0]  count,
  output logic              match_flag,
  output logic              wake_flag,
  output logic              irq,
  output logic              active,
  output logic              rst_busy,
  output logic              toggle_out
);
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cmp;
  tmr_ctrl_t        ctrl_q;
  logic             restart, cnt_wr, clr_match, clr_wake;
  logic             stop, tick, evt_pulse;

  gp_timer_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stop(stop), .psc(psc), .cmp(cmp), .ctrl(ctrl_q), .active(active),
    .restart(restart), .cnt_wr(cnt_wr), .clr_match(clr_match), .clr_wake(clr_wake)
  );

  gp_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst(rst), .evt_in(evt_in), .phase(ctrl_q.phase), .pulse(evt_pulse)
  );

  gp_timer_prescale #(.PSC_W(PSC_W)) i_psc (
    .clk(clk), .rst(rst), .psc(psc), .active(active), .busy(rst_busy),
    .evt_mode(ctrl_q.evt), .evt_pulse(evt_pulse), .restart(restart), .tick(tick)
  );

  gp_timer_count #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .cnt_wr(cnt_wr),
    .cmp(cmp), .mode(ctrl_q.mode), .ien(ctrl_q.ien), .wen(ctrl_q.wen),
    .clr_match(clr_match), .clr_wake(clr_wake), .count(count),
    .match_flag(match_flag), .wake_flag(wake_flag), .toggle_out(toggle_out),
    .busy(rst_busy), .stop(stop)
  );

  assign irq = match_flag && ctrl_q.ien;
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] count,
  input logic             active,
  input logic             match_flag,
  input logic             wake_flag,
  input logic             irq,
  input logic             rst_busy,
  input logic             toggle_out,
  input logic [1:0]       mode,
  input logic             wake_en
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_en) |=> $stable(count)); // R3

  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(match_flag) |-> $past(wr_en)); // R4

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_flag) && $past(mode) == 2'd0) |-> !active); // R5

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(toggle_out) |-> match_flag); // R7

  AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (rst)
    rst_busy |-> (count == '0)); // R11

  AST_IRQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag); // R12

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> ($past(irq) && $past(wake_en))); // R12
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .count(count), .active(active),
  .match_flag(match_flag), .wake_flag(wake_flag), .irq(irq),
  .rst_busy(rst_busy), .toggle_out(toggle_out), .mode(ctrl_q.mode),
  .wake_en(ctrl_q.wen)
);

// File: tb/test_gp_timer.sv
`timescale 1ns/1ps
module test_gp_timer;
  localparam int CNT_W = 10;
  localparam int RST_HOLD = 2;
  localparam int MASK = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic evt_in = 1'b0;
  logic [CNT_W-1:0] count;
  logic match_flag, wake_flag, irq, active, rst_busy, toggle_out;

  always #4 clk = ~clk;

  gp_timer #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) i_gp_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_in(evt_in), .count(count), .match_flag(match_flag),
    .wake_flag(wake_flag), .irq(irq), .active(active), .rst_busy(rst_busy),
    .toggle_out(toggle_out)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_tag = "R2";

  // behavioural reference state
  int m_psc, m_mode, m_ien, m_wen, m_evt, m_ph, m_cmp;
  int m_en[3];
  int m_pc, m_cnt, m_mf, m_wf, m_tg, m_busy;
  int m_sync[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_psc = 0; m_mode = 0; m_ien = 0; m_wen = 0; m_evt = 0; m_ph = 0; m_cmp = 0;
      m_en[0] = 0; m_en[1] = 0; m_en[2] = 0;
      m_pc = 0; m_cnt = 0; m_mf = 0; m_wf = 0; m_tg = 0; m_busy = 0;
      m_sync = '{0, 0, 0};
    end else begin
      bit w_ctrl, w_cmp, w_stat, w_cnt, edge_seen, tick, restart, hit;
      int n_cnt, n_pc, n_mf, n_wf;
      w_ctrl = wr_en && wr_sel == 2'd0;
      w_cmp  = wr_en && wr_sel == 2'd1;
      w_stat = wr_en && wr_sel == 2'd2;
      w_cnt  = wr_en && wr_sel == 2'd3;
      edge_seen = m_ph ? (m_sync[1] == 1 && m_sync[2] == 0) : (m_sync[1] == 0 && m_sync[2] == 1);
      tick = m_en[2] == 1 && m_busy == 0 && (m_evt ? edge_seen : m_pc == m_psc);
      restart = w_cnt || (w_cmp && m_mode != 3) || (w_ctrl && int'(wr_data[7:0]) != m_psc);
      hit = tick && (((m_cnt + 1) & MASK) == m_cmp);
      if (restart) n_cnt = 0;
      else if (tick) n_cnt = (hit && m_mode != 3) ? 0 : ((m_cnt + 1) & MASK);
      else n_cnt = m_cnt;
      if (restart) n_pc = 0;
      else if (m_en[2] == 1 && !m_evt && m_busy == 0) n_pc = (m_pc == m_psc) ? 0 : m_pc + 1;
      else n_pc = m_pc;
      n_mf = (hit || (m_mf && !(w_stat && wr_data[0]))) ? 1 : 0;
      n_wf = ((m_mf && m_ien && m_wen) || (m_wf && !(w_stat && wr_data[1]))) ? 1 : 0;
      if (hit && m_mode == 2) m_tg = 1 - m_tg;
      m_busy = w_cnt ? RST_HOLD : (m_busy > 0 ? m_busy - 1 : 0);
      m_en[2] = m_en[1];
      m_en[1] = m_en[0];
      if (w_ctrl) m_en[0] = wr_data[10];
      if (hit && m_mode == 0) begin m_en[0] = 0; m_en[1] = 0; m_en[2] = 0; end
      if (w_ctrl) begin
        m_psc = int'(wr_data[7:0]); m_mode = int'(wr_data[9:8]);
        m_ien = wr_data[11]; m_wen = wr_data[12]; m_evt = wr_data[13]; m_ph = wr_data[14];
      end
      if (w_cmp) m_cmp = int'(wr_data[CNT_W-1:0]);
      void'(m_sync.pop_back());
      m_sync.push_front(int'(evt_in));
      m_cnt = n_cnt; m_pc = n_pc; m_mf = n_mf; m_wf = n_wf;
    end
    if (cyc >= 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(cur_tag, int'(count), m_cnt);
      check("R3", int'(active), m_en[2]);
      check("R4", int'(match_flag), m_mf);
      check("R12", int'(wake_flag), m_wf);
      check("R12", int'(irq), (m_mf && m_ien) ? 1 : 0);
      check("R7", int'(toggle_out), m_tg);
      check("R11", int'(rst_busy), m_busy != 0 ? 1 : 0);
    end
  end

  function automatic logic [31:0] ctl(int psc, int mode, int en, int ien, int wen, int evt, int ph);
    return 32'(psc & 255) | (32'(mode & 3) << 8) | (32'(en & 1) << 10) |
           (32'(ien & 1) << 11) | (32'(wen & 1) << 12) | (32'(evt & 1) << 13) |
           (32'(ph & 1) << 14);
  endfunction

  task automatic wr(int sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int seen_pass;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: all outputs clear after reset
    check("R1", int'(count), 0);
    check("R1", int'(match_flag) + int'(wake_flag) + int'(irq), 0);
    check("R1", int'(active) + int'(rst_busy) + int'(toggle_out), 0);
    cmp_on = 1;

    // R2 / R3 / R6: periodic, prescale 2, compare 6
    cur_tag = "R2";
    wr(1, 32'd6);
    wr(0, ctl(2, 1, 1, 0, 0, 0, 0));
    check("R3", int'(active), 0);
    idle(1);
    check("R3", int'(active), 0);
    idle(1);
    check("R3", int'(active), 1);
    cur_tag = "R6";
    idle(60);
    check("R6", int'(active), 1);
    check("R6", int'(match_flag), 1);

    // R4: clear match flag
    wr(2, 32'h1);
    check("R4", int'(match_flag), m_mf);

    // R9: compare rewrite restarts in periodic mode
    cur_tag = "R9";
    idle(4);
    wr(1, 32'd9);
    check("R9", int'(count), 0);
    idle(20);

    // R10: prescale change restarts
    cur_tag = "R10";
    idle(3);
    wr(0, ctl(0, 1, 1, 0, 0, 0, 0));
    check("R10", int'(count), 0);
    idle(10);

    // R11: count reset hold window
    cur_tag = "R11";
    idle(3);
    wr(3, 32'd0);
    check("R11", int'(rst_busy), 1);
    check("R11", int'(count), 0);
    idle(1);
    check("R11", int'(rst_busy), 1);
    check("R11", int'(count), 0);
    idle(1);
    check("R11", int'(rst_busy), 0);
    idle(10);

    // R7: toggle mode
    cur_tag = "R7";
    wr(1, 32'd4);
    wr(0, ctl(1, 2, 1, 0, 0, 0, 0));
    idle(40);
    check("R7", int'(active), 1);

    // R12: interrupt and wake
    cur_tag = "R12";
    wr(2, 32'h3);
    wr(0, ctl(1, 2, 1, 1, 1, 0, 0));
    idle(20);
    check("R12", int'(wake_flag), 1);
    wr(2, 32'h2);
    idle(6);

    // R5: one-shot
    cur_tag = "R5";
    wr(0, ctl(3, 0, 0, 0, 0, 0, 0));
    wr(2, 32'h3);
    wr(1, 32'd5);
    wr(0, ctl(3, 0, 1, 0, 0, 0, 0));
    idle(40);
    check("R5", int'(active), 0);
    check("R5", int'(count), 0);
    check("R5", int'(match_flag), 1);

    // R8: continuous, wraps and ignores compare rewrites
    cur_tag = "R8";
    wr(2, 32'h1);
    wr(1, 32'd3);
    wr(0, ctl(0, 3, 1, 0, 0, 0, 0));
    idle(20);
    seen_pass = (int'(count) > 3) ? 1 : 0;
    check("R8", seen_pass, 1);
    wr(1, 32'd700);
    check("R8", int'(count), m_cnt);
    idle(1100);

    // R13: event mode, rising then falling edges
    cur_tag = "R13";
    wr(0, ctl(0, 3, 0, 0, 0, 0, 0));
    wr(3, 32'd0);
    idle(4);
    wr(0, ctl(0, 3, 1, 0, 0, 1, 1));
    idle(3);
    for (int i = 0; i < 12; i++) begin
      evt_in = ~evt_in;
      idle(3);
    end
    check("R13", int'(count), 6);
    wr(0, ctl(0, 3, 1, 0, 0, 1, 0));
    for (int i = 0; i < 8; i++) begin
      evt_in = ~evt_in;
      idle(3);
    end
    check("R13", int'(count), 10);
    idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule